// File: doc/BRIEF.md
# Bit-Slice ALU with Condition Codes

This block is a 32-bit arithmetic logic unit made from identical one-bit slices joined by a ripple carry chain. Every slice holds a full adder, an XOR gate that can invert its b bit, and AND, OR and XOR gates. A four-way selector in each slice picks the adder sum or one of the three logic results. A 3-bit function code controls the unit. The top bit, `fn[2]`, inverts b and also drives the carry into bit 0, so the same adder performs a − b. Because the logic gates also see the possibly inverted b, the code selects eight distinct functions.

The unit also derives four condition flags from the result and the carry chain: negative, zero, carry and overflow. These flags are produced for every function code. For a logic function, the carry and overflow flags still report what the adder computed on the same operands. The result and the flags are captured in output registers on the rising clock edge, and a synchronous active-high reset clears those registers.

Top module: `alu_cc`

## Requirements
- R1: With `fn` = 3'b000, `result` equals `a + b` modulo 2^32.
- R2: With `fn` = 3'b100, `b` is inverted and the carry into bit 0 is 1, so `result` equals `a - b` modulo 2^32.
- R3: `fn[1:0]` selects the result source: 2'b00 selects the adder sum, 2'b01 selects `a & bx`, 2'b10 selects `a | bx`, and 2'b11 selects `a ^ bx`. Here `bx` is `~b` when `fn[2]` = 1 and `b` otherwise.
- R4: `flag_n` equals bit 31 of `result`.
- R5: `flag_z` is 1 exactly when every bit of `result` is 0.
- R6: `flag_c` is the carry out of bit 31 of `a + bx + fn[2]`, for every function code.
- R7: `flag_v` is the XOR of the carry into bit 31 and the carry out of bit 31 of the same sum, for every function code.
- R8: Outputs take the value of the inputs present at the previous rising edge. While `rst` is high at a rising edge, `result` and all four flags become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a | input | 32 | First operand |
| b | input | 32 | Second operand (inverted when fn[2] = 1) |
| fn | input | 3 | Function code: {invert/carry-in, select[1:0]} |
| result | output | 32 | Registered selected result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry out of the most significant bit |
| flag_v | output | 1 | Signed overflow flag |

## Verification
A table of hand-worked vectors covers cases where only one interpretation of a flag gives the listed value:
- 0x7FFFFFFF + 1 sets overflow without carry.
- 0x80000000 − 1 sets both carry and overflow.
- 0 − 0 gives zero with carry set.
- Two equal negative numbers added make carry and overflow appear under an XOR code.
- Logic codes with `fn[2]` set show whether the logic gates see the inverted b.

Random operands over all eight codes then separate select-mapping errors from carry-chain errors. A mid-stream reset shows that the output registers clear.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    PICK_SUM = 2'b00,
    PICK_AND = 2'b01,
    PICK_OR  = 2'b10,
    PICK_XOR = 2'b11
  } pick_t;

  typedef struct packed {
    logic neg;
    logic zero;
    logic cout;
    logic ovf;
  } cc_t;
endpackage

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
(
  input  logic  a_i,
  input  logic  b_i,
  input  logic  inv,
  input  pick_t pick,
  input  logic  c_i,
  output logic  r_o,
  output logic  c_o
);
  logic bx, h1_s, h1_c, h2_s, h2_c;

  assign bx = b_i ^ inv;

  // two half adders plus an OR form the full adder
  assign h1_s = a_i ^ bx;
  assign h1_c = a_i & bx;
  assign h2_s = h1_s ^ c_i;
  assign h2_c = h1_s & c_i;
  assign c_o  = h1_c | h2_c;

  always_comb begin
    unique case (pick)
      PICK_SUM: r_o = h2_s;
      PICK_AND: r_o = a_i & bx;
      PICK_OR:  r_o = a_i | bx;
      PICK_XOR: r_o = h1_s;
      default:  r_o = h2_s;
    endcase
  end
endmodule

// File: rtl/alu_chain.sv
module alu_chain
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [2:0]       fn,
  output logic [WIDTH-1:0] res,
  output logic [WIDTH:0]   carry
);
  pick_t pick;
  assign pick     = pick_t'(fn[1:0]);
  assign carry[0] = fn[2];

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    alu_slice u_slice (
      .a_i  (a[i]),
      .b_i  (b[i]),
      .inv  (fn[2]),
      .pick (pick),
      .c_i  (carry[i]),
      .r_o  (res[i]),
      .c_o  (carry[i+1])
    );
  end
endmodule

// File: rtl/alu_flags.sv
module alu_flags
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] res,
  input  logic [WIDTH:0]   carry,
  output cc_t              cc
);
  localparam int MSB = WIDTH - 1;

  assign cc.neg  = res[MSB];
  assign cc.zero = ~|res;
  assign cc.cout = carry[WIDTH];
  assign cc.ovf  = carry[WIDTH] ^ carry[MSB];
endmodule

// File: rtl/alu_cc.sv
module alu_cc
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [2:0]       fn,
  output logic [WIDTH-1:0] result,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_c,
  output logic             flag_v
);
  logic [WIDTH-1:0] res_d;
  logic [WIDTH:0]   carry;
  cc_t              cc_d;

  alu_chain #(.WIDTH(WIDTH)) u_chain (
    .a     (a),
    .b     (b),
    .fn    (fn),
    .res   (res_d),
    .carry (carry)
  );

  alu_flags #(.WIDTH(WIDTH)) u_flags (
    .res   (res_d),
    .carry (carry),
    .cc    (cc_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      flag_n <= 1'b0;
      flag_z <= 1'b0;
      flag_c <= 1'b0;
      flag_v <= 1'b0;
    end else begin
      result <= res_d;
      flag_n <= cc_d.neg;
      flag_z <= cc_d.zero;
      flag_c <= cc_d.cout;
      flag_v <= cc_d.ovf;
    end
  end
endmodule

// File: rtl/alu_cc_chk.sv
module alu_cc_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic [2:0]       fn,
  input logic [WIDTH-1:0] result,
  input logic             flag_n,
  input logic             flag_z,
  input logic             flag_c,
  input logic             flag_v
);
  logic live;
  always_ff @(posedge clk) live <= !rst;

  // R1
  add_path_chk: assert property (@(posedge clk) disable iff (rst)
    (live && $past(fn) == 3'b000) |-> result == $past(a) + $past(b));

  // R2
  sub_path_chk: assert property (@(posedge clk) disable iff (rst)
    (live && $past(fn) == 3'b100) |-> result == $past(a) - $past(b));

  // R4
  neg_flag_chk: assert property (@(posedge clk) disable iff (rst)
    live |-> flag_n == result[WIDTH-1]);

  // R5
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    live |-> flag_z == (result == '0));

  // R7
  add_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (live && $past(fn) == 3'b000) |->
      flag_v == (($past(a[WIDTH-1]) == $past(b[WIDTH-1])) &&
                 (result[WIDTH-1] != $past(a[WIDTH-1]))));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (result == '0 && !flag_n && !flag_z && !flag_c && !flag_v));
endmodule

bind alu_cc alu_cc_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_alu_cc.sv
module sim_alu_cc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] a = '0, b = '0;
  logic [2:0]  fn = '0;
  logic [31:0] result;
  logic        flag_n, flag_z, flag_c, flag_v;
  int          n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  alu_cc u0 (.*);

  // {a, b, fn, result, n, z, c, v}
  localparam int NV = 9;
  localparam logic [102:0] VEC [NV] = '{
    {32'h7FFFFFFF, 32'h00000001, 3'b000, 32'h80000000, 4'b1001},
    {32'h80000000, 32'h00000001, 3'b100, 32'h7FFFFFFF, 4'b0011},
    {32'h00000000, 32'h00000000, 3'b100, 32'h00000000, 4'b0110},
    {32'hF0F0F0F0, 32'hFF00FF00, 3'b001, 32'hF000F000, 4'b1010},
    {32'hFFFFFFFF, 32'h0000FFFF, 3'b101, 32'hFFFF0000, 4'b1010},
    {32'h00000000, 32'hFFFFFFFF, 3'b110, 32'h00000000, 4'b0100},
    {32'h12345678, 32'h12345678, 3'b111, 32'hFFFFFFFF, 4'b1010},
    {32'hA5A5A5A5, 32'hA5A5A5A5, 3'b011, 32'h00000000, 4'b0111},
    {32'h0F0F0000, 32'h00000F0F, 3'b010, 32'h0F0F0F0F, 4'b0000}
  };

  task automatic check(string req, logic [35:0] got, logic [35:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h (result,nzcv)", req, got, exp);
    end
  endtask

  function automatic logic [35:0] model(logic [31:0] x, logic [31:0] y, logic [2:0] f);
    logic [31:0] yx, r;
    logic [32:0] s;
    logic        v;
    yx = f[2] ? ~y : y;
    s  = {1'b0, x} + {1'b0, yx} + {32'b0, f[2]};
    v  = (x[31] == yx[31]) && (s[31] != x[31]);
    case (f[1:0])
      2'b00: r = s[31:0];
      2'b01: r = x & yx;
      2'b10: r = x | yx;
      default: r = x ^ yx;
    endcase
    return {r, r[31], r == 32'h0, s[32], v};
  endfunction

  task automatic apply(logic [31:0] x, logic [31:0] y, logic [2:0] f);
    @(negedge clk);
    a = x; b = y; fn = f;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 reset", {result, flag_n, flag_z, flag_c, flag_v}, 36'h0);
    rst = 1'b0;

    // R1 R2 R3 R4 R5 R6 R7 directed table
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][102:71], VEC[i][70:39], VEC[i][38:36]);
      check(i < 3 ? "R1/R2/R6/R7 corner" : "R3/R4/R5 select",
            {result, flag_n, flag_z, flag_c, flag_v}, VEC[i][35:0]);
    end

    // R1-style random sweep across all codes: R3 R6 R7
    for (int i = 0; i < 400; i++) begin
      logic [31:0] x, y;
      logic [2:0]  f;
      x = $urandom; y = $urandom; f = 3'(i % 8);
      if (i % 17 == 0) y = x;
      apply(x, y, f);
      check("R3 R6 R7 random", {result, flag_n, flag_z, flag_c, flag_v}, model(x, y, f));
    end

    // R8 registered timing and reset clears
    @(negedge clk);
    a = 32'hFFFFFFFF; b = 32'h1; fn = 3'b000;
    @(negedge clk);
    check("R8 latency", {result, flag_n, flag_z, flag_c, flag_v}, 36'h0_0000_0006);
    rst = 1'b1;
    @(negedge clk);
    check("R8 reset clears", {result, flag_n, flag_z, flag_c, flag_v}, 36'h0);
    rst = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule